// File: doc/BRIEF.md
# Converter Test Pattern Source

This block sits between a 14-bit sample source and the framing logic that follows it. In normal operation it hands each converter sample on unchanged. For link bring-up it can replace the samples with a fixed or sequenced test word instead. The result is registered, so every mode has the same one-cycle latency.

A 4-bit selector chooses the pattern. The choices are constant words (all zeros, all ones, a deskew word and a sync word), a bit-alternating toggle, an incrementing ramp, and two words supplied from outside the block. The outside words can be repeated on their own or used in alternation. Sequenced patterns advance one step per sample clock. Whenever the selector value differs from the one seen on the previous clock, the sequence restarts.

Top module: `adc_tpg`

## Requirements
- R1: With `mode_sel` = 0000, `pat_out` equals the `conv_data` value presented one clock earlier.
- R2: Code 0001 yields 14'h0000 and code 0010 yields 14'h3FFF.
- R3: Code 0011 yields 14'h2AAA (binary 10101010101010) on its first clock and then flips every clock between that word and 14'h1555.
- R4: Code 0100 yields a ramp that starts at 0 and rises by one each clock, returning to 0 after 14'h3FFF.
- R5: Code 0110 yields the `user_pat_a` value presented one clock earlier, on every clock.
- R6: Code 0111 yields `user_pat_a` on its first clock and `user_pat_b` on its second, alternating after that; each word is sampled on the clock it is selected.
- R7: Code 1000 yields the deskew word 14'h2AAA and code 1001 yields the sync word 14'h3FFF.
- R8: Codes 0101 and 1010 through 1111 behave exactly as pass-through (R1).
- R9: When `mode_sel` differs from its value on the previous clock, the toggle, ramp and alternating-word sequences start from their first step (2AAA, 0, `user_pat_a`). The selector is treated as 0000 before the first clock after reset.
- R10: Every mode has exactly one register stage between the inputs and `pat_out`.
- R11: While `rst_n` is low, `pat_out` is 0 immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 4 | Pattern selector code |
| conv_data | input | 14 | Converter sample |
| user_pat_a | input | 14 | First externally supplied word |
| user_pat_b | input | 14 | Second externally supplied word |
| pat_out | output | 14 | Registered word to the framing logic |

## Verification
The internal state is small: the previous selector value and the step counter. A fault in that state shows up at `pat_out` within two clocks of a mode change. A counter that fails to clear starts a ramp at a nonzero value, or starts the toggle or alternation on the wrong phase. A counter that fails to advance repeats a value. A wrong wrap length can only be seen after 16384 ramp steps, so one ramp run is held past the wrap point. Random selector changes, some of them only one clock long, cover the case where a phase is restarted right after it began.

// File: rtl/adc_tpg_pkg.sv
package adc_tpg_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    TPG_LIVE   = 4'd0,
    TPG_ZERO   = 4'd1,
    TPG_ONES   = 4'd2,
    TPG_TOGGLE = 4'd3,
    TPG_RAMP   = 4'd4,
    TPG_USER1  = 4'd6,
    TPG_USER12 = 4'd7,
    TPG_DESKEW = 4'd8,
    TPG_SYNC   = 4'd9
  } tpg_mode_e;

  // Modes whose output depends on the step counter.
  function automatic logic is_sequenced(input logic [MODE_W-1:0] m);
    return (m == TPG_TOGGLE) || (m == TPG_RAMP) || (m == TPG_USER12);
  endfunction

endpackage

// File: rtl/adc_tpg_step.sv
module adc_tpg_step
  import adc_tpg_pkg::*;
#(
  parameter int W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  output logic [W-1:0]      step_o
);

  logic [MODE_W-1:0] mode_q;
  logic [W-1:0]      cnt_q;
  logic [W-1:0]      cnt_d;
  logic              mode_chg;
  logic              cnt_en;

  // Next-state logic: restart on any selector change, otherwise advance.
  always_comb begin
    mode_chg = (mode_i != mode_q);
    cnt_en   = mode_chg || is_sequenced(mode_i);
    cnt_d    = mode_chg ? '0 : cnt_q + W'(1);
  end

  assign step_o = cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_i;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

endmodule

// File: rtl/adc_tpg_sel.sv
module adc_tpg_sel
  import adc_tpg_pkg::*;
#(
  parameter int W = 14
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [W-1:0]      step_i,
  input  logic [W-1:0]      live_i,
  input  logic [W-1:0]      pat_a_i,
  input  logic [W-1:0]      pat_b_i,
  output logic [W-1:0]      word_o
);

  // Alternating word with a one in the MSB position for even W (2AAA at 14 bits).
  logic [W-1:0] alt_word;

  for (genvar i = 0; i < W; i++) begin : g_alt
    assign alt_word[i] = ((i % 2) == 1);
  end

  always_comb begin
    case (mode_i)
      TPG_ZERO:   word_o = '0;
      TPG_ONES:   word_o = '1;
      TPG_TOGGLE: word_o = step_i[0] ? ~alt_word : alt_word;
      TPG_RAMP:   word_o = step_i;
      TPG_USER1:  word_o = pat_a_i;
      TPG_USER12: word_o = step_i[0] ? pat_b_i : pat_a_i;
      TPG_DESKEW: word_o = alt_word;
      TPG_SYNC:   word_o = '1;
      default:    word_o = live_i;
    endcase
  end

endmodule

// File: rtl/adc_tpg.sv
module adc_tpg
  import adc_tpg_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [DATA_W-1:0] user_pat_a,
  input  logic [DATA_W-1:0] user_pat_b,
  output logic [DATA_W-1:0] pat_out
);

  logic [DATA_W-1:0] step;
  logic [DATA_W-1:0] word_d;
  logic [DATA_W-1:0] out_q;

  adc_tpg_step #(.W(DATA_W)) u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_sel),
    .step_o (step)
  );

  adc_tpg_sel #(.W(DATA_W)) u_sel (
    .mode_i  (mode_sel),
    .step_i  (step),
    .live_i  (conv_data),
    .pat_a_i (user_pat_a),
    .pat_b_i (user_pat_b),
    .word_o  (word_d)
  );

  // Single output stage shared by every mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= word_d;
    end
  end

  assign pat_out = out_q;

endmodule

// File: rtl/adc_tpg_checker.sv
module adc_tpg_checker #(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   mode_sel,
  input logic [W-1:0] conv_data,
  input logic [W-1:0] user_pat_a,
  input logic [W-1:0] user_pat_b,
  input logic [W-1:0] pat_out
);

  function automatic logic [W-1:0] alt_ref();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = ((i % 2) == 1);
    return r;
  endfunction

  logic [3:0] mode_prev;
  logic       vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_prev <= '0;
      vld       <= 1'b0;
    end else begin
      mode_prev <= mode_sel;
      vld       <= 1'b1;
    end
  end

  assert_pass_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 4'd0) |=> (pat_out == $past(conv_data)));

  assert_zero_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 4'd1) |=> (pat_out == '0));

  assert_ones_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 4'd2) |=> (pat_out == '1));

  assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && mode_sel == 4'd3 && mode_prev == 4'd3) |=> (pat_out == ~$past(pat_out)));

  assert_ramp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && mode_sel == 4'd4 && mode_prev == 4'd4) |=> (pat_out == W'($past(pat_out) + W'(1))));

  assert_user_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 4'd6) |=> (pat_out == $past(user_pat_a)));

  assert_user_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && mode_sel == 4'd7 && mode_prev != 4'd7) ##1 (mode_sel == 4'd7)
      |=> (pat_out == $past(user_pat_b)));

  assert_deskew_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 4'd8) |=> (pat_out == alt_ref()));

  assert_sync_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 4'd9) |=> (pat_out == '1));

  assert_unused_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 4'd5 || mode_sel >= 4'd10) |=> (pat_out == $past(conv_data)));

  assert_ramp_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && mode_sel == 4'd4 && mode_prev != 4'd4) |=> (pat_out == '0));

  assert_user_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && mode_sel == 4'd7 && mode_prev != 4'd7) |=> (pat_out == $past(user_pat_a)));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_zero_R11: assert (pat_out == '0)
        else $error("output not cleared in reset");
    end
  end

endmodule

bind adc_tpg adc_tpg_checker #(.W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .conv_data  (conv_data),
  .user_pat_a (user_pat_a),
  .user_pat_b (user_pat_b),
  .pat_out    (pat_out)
);

// File: tb/adc_tpg_bench.sv
module adc_tpg_bench;

  localparam int  W   = 14;
  localparam time TCK = 4ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   mode_sel;
  logic [W-1:0] conv_data, user_pat_a, user_pat_b, pat_out;

  int           n_chk = 0;
  int           n_err = 0;
  logic [3:0]   m_prev;
  logic [W-1:0] m_step;
  logic [W-1:0] exp_q;
  string        exp_req;

  always #(TCK/2) clk = ~clk;

  adc_tpg #(.DATA_W(W)) u_adc_tpg (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .conv_data(conv_data),
    .user_pat_a(user_pat_a), .user_pat_b(user_pat_b), .pat_out(pat_out)
  );

  function automatic logic [W-1:0] alt_word();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = ((i % 2) == 1);
    return r;
  endfunction

  function automatic logic [W-1:0] model_word(input logic [3:0] m, input logic [W-1:0] s,
                                              input logic [W-1:0] d, input logic [W-1:0] a,
                                              input logic [W-1:0] b);
    case (m)
      4'd1:    return '0;
      4'd2:    return '1;
      4'd3:    return s[0] ? ~alt_word() : alt_word();
      4'd4:    return s;
      4'd6:    return a;
      4'd7:    return s[0] ? b : a;
      4'd8:    return alt_word();
      4'd9:    return '1;
      default: return d;
    endcase
  endfunction

  function automatic string req_tag(input logic [3:0] m, input bit chg);
    case (m)
      4'd0:       return "R1 R10";
      4'd1, 4'd2: return "R2";
      4'd3:       return chg ? "R9" : "R3";
      4'd4:       return chg ? "R9" : "R4";
      4'd6:       return "R5";
      4'd7:       return chg ? "R9" : "R6";
      4'd8, 4'd9: return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic apply(input logic [3:0] m, input logic [W-1:0] d,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    bit           chg;
    logic [W-1:0] s;
    mode_sel   = m;
    conv_data  = d;
    user_pat_a = a;
    user_pat_b = b;
    chg        = (m != m_prev);
    s          = chg ? '0 : W'(m_step + W'(1));
    exp_q      = model_word(m, s, d, a, b);
    exp_req    = req_tag(m, chg);
    m_prev     = m;
    m_step     = s;
  endtask

  task automatic cycle(input logic [3:0] m, input logic [W-1:0] d,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    check(pat_out, exp_q, exp_req);
    apply(m, d, a, b);
  endtask

  function automatic logic [W-1:0] rnd();
    return W'($urandom);
  endfunction

  task automatic cycle_rnd(input logic [3:0] m);
    cycle(m, rnd(), rnd(), rnd());
  endtask

  task automatic do_reset();
    @(negedge clk);
    check(pat_out, exp_q, exp_req);
    rst_n    = 1'b0;
    mode_sel = 4'd4;
    #1;
    check(pat_out, '0, "R11");
    repeat (2) @(negedge clk);
    check(pat_out, '0, "R11");
    m_prev = '0;
    m_step = '0;
    rst_n  = 1'b1;
    apply(4'd0, rnd(), rnd(), rnd());
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(TCK * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] ua, ub;
    void'($urandom(32'd77231));
    rst_n = 1'b1; mode_sel = '0; conv_data = '0; user_pat_a = '0; user_pat_b = '0;
    m_prev = '0; m_step = '0; exp_q = '0; exp_req = "R11";
    #1 rst_n = 1'b0;
    #1 check(pat_out, '0, "R11");
    repeat (3) @(negedge clk);
    check(pat_out, '0, "R11");
    rst_n = 1'b1;
    apply(4'd0, rnd(), rnd(), rnd());

    // R1 R10 pass-through
    for (int i = 0; i < 6; i++) cycle_rnd(4'd0);
    // R2 constants
    for (int i = 0; i < 3; i++) cycle_rnd(4'd1);
    for (int i = 0; i < 3; i++) cycle_rnd(4'd2);
    // R8 unused codes
    cycle_rnd(4'd5); cycle_rnd(4'd5);
    for (int c = 10; c < 16; c++) begin
      cycle_rnd(4'(c)); cycle_rnd(4'(c));
    end
    // R3 toggle
    for (int i = 0; i < 7; i++) cycle_rnd(4'd3);
    // R7 deskew and sync
    for (int i = 0; i < 3; i++) cycle_rnd(4'd8);
    for (int i = 0; i < 3; i++) cycle_rnd(4'd9);
    // R5 single user word
    for (int i = 0; i < 5; i++) cycle_rnd(4'd6);
    // R6 alternating user words, fixed and changing
    ua = 14'h1234; ub = 14'h0ABC;
    for (int i = 0; i < 6; i++) cycle(4'd7, rnd(), ua, ub);
    for (int i = 0; i < 6; i++) cycle_rnd(4'd7);
    // R4 ramp held past the wrap point
    for (int i = 0; i < 16390; i++) cycle_rnd(4'd4);
    // R9 restarts with short dwell
    cycle_rnd(4'd3); cycle_rnd(4'd4); cycle_rnd(4'd4); cycle_rnd(4'd7);
    cycle_rnd(4'd4); cycle_rnd(4'd3); cycle_rnd(4'd3); cycle_rnd(4'd7);
    cycle_rnd(4'd7); cycle_rnd(4'd0); cycle_rnd(4'd4); cycle_rnd(4'd4);
    // R11 mid-run reset while ramping
    do_reset();
    for (int i = 0; i < 4; i++) cycle_rnd(4'd4);
    // Random segments
    for (int seg = 0; seg < 400; seg++) begin
      logic [3:0] m;
      int         len;
      m   = 4'($urandom_range(0, 15));
      len = int'($urandom_range(1, 12));
      for (int k = 0; k < len; k++) cycle_rnd(m);
    end
    @(negedge clk);
    check(pat_out, exp_q, exp_req);
    finish_run();
  end

endmodule